// File: doc/BRIEF.md
# Reconfigurable Product Term Array

This block is the programmable AND plane of a small logic array. Twenty logic inputs each feed two array columns, one true and one inverted, so forty columns in all. Sixty-four product terms are formed across those columns. They are grouped eight to a cell for eight downstream output cells. Each term is the AND of every column whose connection fuse is kept. A per-term keep bit can switch any single term off.

All configuration lives in one linear fuse map held in flip-flops. The map holds the connection fuses, the keep bits, two local architecture bits per output cell, two global architecture bits and a 64-bit user signature row. An addressed write port sets single map bits, and an addressed read port returns them one cycle later. A lock input hides every map bit except the signature row from the read port. Only a clear or a reset removes the lock. A clear returns the whole map to its erased state, where every bit is 1.

The architecture bits leave the block as plain outputs for the output cells to decode. The product terms are combinational from the inputs and the current map.

Top module: `pta_array`

## Requirements
- R1: After reset every map bit is 1 and `locked` is 0. All product terms therefore read 0, and every architecture output reads 1.
- R2: Column 2i carries `in_vec[i]` and column 2i+1 carries its inverse. The fuse for term t and column c is at map address t*40+c, and a stored 1 means connected. A kept term is the AND of its connected columns.
- R3: A term whose forty fuses are all 1 (the erased pattern) reads 0 for every input value.
- R4: A kept term with every fuse at 0 reads 1 for every input value.
- R5: The keep bit of term t is at address 2640+t. While it is 0, `pterm[t]` is 0 whatever the inputs and fuses are.
- R6: `pterm[8k+j]` is term j of output cell k, and its fuse row starts at address 320k+40j.
- R7: Local bit one of cell c is at address 2567-c and drives `cl1_bits[c]`. Local bit zero of cell c is at address 2639-c and drives `cl0_bits[c]`. Global bit one is at 2704 (`cg1_bit`) and global bit zero is at 2705 (`cg0_bit`). Each output follows its map bit from the cycle after the write.
- R8: With `rd_en` high, `rd_data` holds the addressed map bit from the next cycle onward. It holds its value while `rd_en` is low. A read of any address at or above 2706 returns 0.
- R9: A `sec_set` pulse sets `locked`, and `locked` stays set until a clear or a reset. While locked, reads of any address outside 2568 to 2631 return 0, and the product terms keep working.
- R10: The signature row, at addresses 2568 to 2631, reads back its stored values whether or not the block is locked.
- R11: A `clr` pulse sets every map bit to 1 and drops `locked`. It overrides a write or a `sec_set` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vec | input | 20 | Logic inputs to the array |
| pterm | output | 64 | Product term results |
| clr | input | 1 | Erase the map and the lock |
| wr_en | input | 1 | Write one map bit |
| wr_addr | input | 12 | Write address |
| wr_bit | input | 1 | Value to write |
| sec_set | input | 1 | Set the readback lock |
| rd_en | input | 1 | Capture one map bit on `rd_data` |
| rd_addr | input | 12 | Read address |
| rd_data | output | 1 | Registered readback bit |
| locked | output | 1 | Readback lock state |
| cl1_bits | output | 8 | Local architecture bit one per cell |
| cl0_bits | output | 8 | Local architecture bit zero per cell |
| cg1_bit | output | 1 | Global architecture bit one |
| cg0_bit | output | 1 | Global architecture bit zero |

## Verification
The hardest state to reach is a product term that is both kept and sensitive to its inputs. From erase, every term is tied to 0 by its own complementary fuse pairs. The stimulus therefore opens all forty fuses of one row one write at a time, then closes exactly three chosen columns. Only then does the input table show a term that can go both ways. A second row is opened fully, so it reads a constant 1 and its keep bit can be seen to force it to 0. The lock is set over a map that already holds known non-erased bits, so a protected read returning 0 shows the lock hiding data rather than an erased bit.

// File: rtl/pta_pkg.sv
package pta_pkg;

  typedef enum logic [2:0] {
    RG_ARRAY,
    RG_CL1,
    RG_SIG,
    RG_CL0,
    RG_KEEP,
    RG_GLOBAL,
    RG_NONE
  } region_e;

  // Sorts a map address into its region from the region end bounds.
  function automatic region_e classify(
    input int unsigned a,
    input int unsigned arr_end,
    input int unsigned cl1_end,
    input int unsigned sig_end,
    input int unsigned cl0_end,
    input int unsigned keep_end,
    input int unsigned map_end
  );
    if (a < arr_end)       return RG_ARRAY;
    else if (a < cl1_end)  return RG_CL1;
    else if (a < sig_end)  return RG_SIG;
    else if (a < cl0_end)  return RG_CL0;
    else if (a < keep_end) return RG_KEEP;
    else if (a < map_end)  return RG_GLOBAL;
    else                   return RG_NONE;
  endfunction

endpackage

// File: rtl/pta_fuse_store.sv
module pta_fuse_store #(
  parameter int MAP_BITS = 2706,
  parameter int AW       = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic                wr_bit,
  input  logic                sec_set,
  output logic [MAP_BITS-1:0] fmap,
  output logic                locked
);

  logic [MAP_BITS-1:0] fmap_nx;
  logic                locked_nx;
  logic                wr_hit;
  logic                map_ce;

  assign wr_hit = wr_en && (32'(wr_addr) < 32'(MAP_BITS));
  assign map_ce = clr || wr_hit;

  always_comb begin
    fmap_nx = fmap;
    if (clr) begin
      fmap_nx = '1;
    end else if (wr_hit) begin
      fmap_nx[wr_addr] = wr_bit;
    end
  end

  always_comb begin
    if (clr)          locked_nx = 1'b0;
    else if (sec_set) locked_nx = 1'b1;
    else              locked_nx = locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmap   <= '1;
      locked <= 1'b0;
    end else begin
      if (map_ce) fmap <= fmap_nx;
      locked <= locked_nx;
    end
  end

  // R11: a clear erases the map and drops the lock
  a_r11_clear_erases: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((&fmap) && !locked));

  // R9: the lock holds until a clear
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clr) |=> locked);

  // R9: a lock request without a clear sets the lock
  a_r9_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_set && !clr) |=> locked);

endmodule

// File: rtl/pta_term.sv
module pta_term #(
  parameter int N_COL = 40
) (
  input  logic [N_COL-1:0] fuses,
  input  logic [N_COL-1:0] cols,
  input  logic             keep,
  output logic             hit
);

  always_comb begin
    hit = keep;
    for (int c = 0; c < N_COL; c++) begin
      if (fuses[c] && !cols[c]) hit = 1'b0;
    end
  end

endmodule

// File: rtl/pta_readback.sv
module pta_readback
  import pta_pkg::*;
#(
  parameter int MAP_BITS = 2706,
  parameter int AW       = 12,
  parameter int ARR_END  = 2560,
  parameter int CL1_END  = 2568,
  parameter int SIG_END  = 2632,
  parameter int CL0_END  = 2640,
  parameter int KEEP_END = 2704
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  input  logic [MAP_BITS-1:0] fmap,
  input  logic                locked,
  output logic                rd_data
);

  region_e rgn;
  logic    raw_bit;
  logic    visible;
  logic    rd_nx;

  always_comb begin
    rgn = classify(32'(rd_addr), ARR_END, CL1_END, SIG_END, CL0_END,
                   KEEP_END, MAP_BITS);
    raw_bit = 1'b0;
    if (rgn != RG_NONE) raw_bit = fmap[rd_addr];
    visible = !locked || (rgn == RG_SIG);
    rd_nx   = raw_bit && visible;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= 1'b0;
    end else if (rd_en) begin
      rd_data <= rd_nx;
    end
  end

  // R8: output holds while no read is requested
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R8: addresses past the map read as zero
  a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (32'(rd_addr) >= 32'(MAP_BITS))) |=> !rd_data);

  // R9: protected regions read as zero while locked
  a_r9_hidden_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && locked && (rgn != RG_SIG)) |=> !rd_data);

  // R10: the signature row stays readable
  a_r10_sig_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rgn == RG_SIG)) |=> (rd_data == $past(raw_bit)));

endmodule

// File: rtl/pta_array.sv
module pta_array #(
  parameter int N_IN     = 20,
  parameter int N_CELL   = 8,
  parameter int TPC      = 8,
  parameter int SIG_BITS = 64,
  localparam int N_COL    = 2 * N_IN,
  localparam int N_TERM   = N_CELL * TPC,
  localparam int ARR_END  = N_TERM * N_COL,
  localparam int CL1_END  = ARR_END + N_CELL,
  localparam int SIG_END  = CL1_END + SIG_BITS,
  localparam int CL0_END  = SIG_END + N_CELL,
  localparam int KEEP_END = CL0_END + N_TERM,
  localparam int MAP_BITS = KEEP_END + 2,
  localparam int AW       = $clog2(MAP_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_TERM-1:0] pterm,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_bit,
  input  logic              sec_set,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_data,
  output logic              locked,
  output logic [N_CELL-1:0] cl1_bits,
  output logic [N_CELL-1:0] cl0_bits,
  output logic              cg1_bit,
  output logic              cg0_bit
);

  logic [MAP_BITS-1:0] fmap;
  logic [N_COL-1:0]    cols;

  pta_fuse_store #(.MAP_BITS(MAP_BITS), .AW(AW)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .sec_set (sec_set),
    .fmap    (fmap),
    .locked  (locked)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_col
    assign cols[2*i]   = in_vec[i];
    assign cols[2*i+1] = ~in_vec[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pta_term #(.N_COL(N_COL)) i_term (
      .fuses (fmap[t*N_COL +: N_COL]),
      .cols  (cols),
      .keep  (fmap[CL0_END + t]),
      .hit   (pterm[t])
    );

    // R5: a cleared keep bit forces the term low
    a_r5_keep_off: assert property (@(posedge clk) disable iff (!rst_n)
      !fmap[CL0_END + t] |-> !pterm[t]);
  end

  for (genvar c = 0; c < N_CELL; c++) begin : g_arch
    assign cl1_bits[c] = fmap[CL1_END - 1 - c];
    assign cl0_bits[c] = fmap[CL0_END - 1 - c];
  end
  assign cg1_bit = fmap[KEEP_END];
  assign cg0_bit = fmap[KEEP_END + 1];

  pta_readback #(
    .MAP_BITS (MAP_BITS),
    .AW       (AW),
    .ARR_END  (ARR_END),
    .CL1_END  (CL1_END),
    .SIG_END  (SIG_END),
    .CL0_END  (CL0_END),
    .KEEP_END (KEEP_END)
  ) i_readback (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .fmap    (fmap),
    .locked  (locked),
    .rd_data (rd_data)
  );

endmodule

// File: tb/test_pta_array.sv
module test_pta_array;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] in_vec;
  logic [63:0] pterm;
  logic        clr, wr_en, wr_bit, sec_set, rd_en;
  logic [11:0] wr_addr, rd_addr;
  logic        rd_data, locked, cg1_bit, cg0_bit;
  logic [7:0]  cl1_bits, cl0_bits;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pta_array i_pta_array (
    .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .pterm(pterm),
    .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .sec_set(sec_set), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .locked(locked), .cl1_bits(cl1_bits),
    .cl0_bits(cl0_bits), .cg1_bit(cg1_bit), .cg0_bit(cg0_bit)
  );

  // {expected term 5, inputs}; term 5 = in0 & ~in1 & ~in19
  localparam logic [20:0] VEC [6] = '{
    {1'b1, 20'h00001}, {1'b0, 20'h00000}, {1'b0, 20'h00003},
    {1'b0, 20'h80001}, {1'b1, 20'h7FFFD}, {1'b0, 20'hFFFFF}
  };

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'(a); wr_bit = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input logic exp);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 12'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, 64'(rd_data), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_vec = '0; clr = 1'b0; wr_en = 1'b0; wr_bit = 1'b0;
    sec_set = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pterm", pterm, 64'h0);
    chk("R1 locked", 64'(locked), 64'h0);
    chk("R1 arch", 64'({cl1_bits, cl0_bits, cg1_bit, cg0_bit}), 64'h3FFFF);
    rd("R1 map bit", 1234, 1'b1);

    // R3 erased rows stay low under varied inputs
    in_vec = 20'hAAAAA; #1 chk("R3 erased", pterm, 64'h0);
    in_vec = 20'hFFFFF; #1 chk("R3 erased", pterm, 64'h0);

    // R2: term 5 -> open its row, then connect in0, ~in1, ~in19
    for (int c = 0; c < 40; c++) wr(200 + c, 1'b0);
    wr(200, 1'b1); wr(203, 1'b1); wr(239, 1'b1);
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      in_vec = VEC[v][19:0];
      #1 chk("R2 table", pterm, 64'(VEC[v][20]) << 5);
    end

    // R4 and R6: cell 1 term 1 (index 9) opens at 320+40
    for (int c = 0; c < 40; c++) wr(360 + c, 1'b0);
    in_vec = 20'h00000; #1 chk("R4 R6 open term", pterm, 64'h1 << 9 | 64'h0);
    in_vec = 20'hFFFFF; #1 chk("R4 open term", pterm, 64'h1 << 9);

    // R5 keep bit of term 9
    wr(2649, 1'b0);
    #1 chk("R5 keep off", pterm, 64'h0);
    wr(2649, 1'b1);
    #1 chk("R5 keep on", pterm, 64'h1 << 9);

    // R7 architecture bits
    wr(2560, 1'b0); wr(2639, 1'b0); wr(2704, 1'b0);
    chk("R7 cl1", 64'(cl1_bits), 64'h7F);
    chk("R7 cl0", 64'(cl0_bits), 64'hFE);
    chk("R7 cg", 64'({cg1_bit, cg0_bit}), 64'h1);

    // R8 readback
    rd("R8 fuse kept", 200, 1'b1);
    rd("R8 fuse cut", 201, 1'b0);
    rd("R8 out of range", 4000, 1'b0);
    rd("R8 fuse kept", 203, 1'b1);
    @(negedge clk); rd_addr = 12'd201;
    @(negedge clk); chk("R8 hold", 64'(rd_data), 64'h1);

    // R10 signature row
    wr(2568, 1'b0); wr(2600, 1'b0);
    rd("R10 sig", 2568, 1'b0);

    // R9 lock
    @(negedge clk); sec_set = 1'b1;
    @(negedge clk); sec_set = 1'b0;
    chk("R9 locked", 64'(locked), 64'h1);
    rd("R9 hidden fuse", 200, 1'b0);
    rd("R9 hidden global", 2705, 1'b0);
    rd("R10 sig locked", 2569, 1'b1);
    rd("R10 sig locked", 2600, 1'b0);
    in_vec = 20'h00001; #1 chk("R9 terms live", pterm, (64'h1 << 5) | (64'h1 << 9));
    repeat (3) @(negedge clk);
    chk("R9 sticky", 64'(locked), 64'h1);

    // R11 clear wins over a same-cycle write
    @(negedge clk); clr = 1'b1; wr_en = 1'b1; wr_addr = 12'd200; wr_bit = 1'b0;
    @(negedge clk); clr = 1'b0; wr_en = 1'b0;
    chk("R11 unlock", 64'(locked), 64'h0);
    chk("R11 pterm", pterm, 64'h0);
    chk("R11 arch", 64'({cl1_bits, cl0_bits, cg1_bit, cg0_bit}), 64'h3FFFF);
    rd("R11 erased fuse", 200, 1'b1);
    rd("R11 erased sig", 2568, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule